// File: doc/BRIEF.md
# LCD Multiplexed Waveform Sequencer

This block produces the drive levels for the common (COM) and segment (SEG) lines of a segmented liquid-crystal panel. It supports four multiplex ratios: static, 1/2, 1/3 and 1/4. Each output line carries a 2-bit index into an external bias ladder, and the ladder turns that index into a voltage. The block is clocked by the system clock. It advances only on cycles where the `tick` enable is high, so `tick` stands for the slow LCD source clock.

A 4-bit prescaler stretches each time slot. The multiplex ratio decides how many commons are scanned in one frame. The waveform select picks one of two balancing policies:

- Type-A inverts the polarity inside every common's slot.
- Type-B inverts the polarity once per frame.

The mode, prescaler and waveform select are sampled only at frame boundaries. A one-cycle strobe marks the start of each frame, and a phase output shows the current polarity.

The control is a two-state machine:

- `ST_IDLE` is entered on reset. All outputs are held at level 0.
- The first `tick` takes the machine from `ST_IDLE` to `ST_RUN`. This transition latches the configuration and starts frame 0.
- In `ST_RUN` every tick advances a sub-slot counter. When the counter wraps, the machine moves to the second half of the slot, then to the next common, and finally wraps the frame. That last transition reloads the configuration and pulses the strobe.
- `ST_RUN` persists until reset.

Top module: `lcd_wave_seq`

## Requirements
- R1: While reset is asserted and until the first `tick` afterwards, every COM and SEG level is 0, and `frame_strobe` and `phase_o` are 0. The first tick starts a frame at common 0 with positive phase.
- R2: A frame lasts the following number of ticks, where LP is the prescaler value:
  - `mux_in`=0 (static): 4·(LP+1).
  - `mux_in`=1 (1/2): 2·2·(LP+1).
  - `mux_in`=2 (1/3) and `mux_in`=3 (1/4) with Type-B: N·(LP+1), where N is 3 or 4.
- R3: `frame_strobe` is high for exactly one clock cycle at the start of each frame. That cycle is the one following the tick that begins the frame.
- R4: Outputs, strobe and phase change only after a clock edge on which `tick` was high.
- R5: Commons are scanned in the order 0, 1, …, N-1, one slot each, and common 0 is active when a frame starts. The active common is at level V in positive phase and at level 0 in negative phase. The bias V is 1 for static, 2 for 1/2 and 3 for 1/3 and 1/4.
- R6: Level encoding:
  - The SEG line of an on pixel (`pix_in` bit = 1, bit index common·NSEG+segment) is at 0 in positive phase.
  - The SEG line of an off pixel is at V in positive phase, except at bias 3, where it is at 2.
  - An inactive common is at 1 in positive phase, except in static mode, where it is at 0.
  - In negative phase every line is at V minus its positive-phase level.
  - No level ever exceeds V.
- R7: Commons numbered above the active multiplex count are held at the inactive-common level of the current phase.
- R8: In Type-A (`type_b_in`=0) each common's slot is split into a positive half followed by an equal negative half. Every pixel's COM−SEG sum over one frame is therefore zero.
- R9: In Type-B (`type_b_in`=1) the phase is constant within a frame and toggles at each boundary where the configuration is unchanged. Every pixel's COM−SEG sum over two consecutive frames is zero.
- R10: Over a balanced window, every on pixel accumulates a larger sum of squared COM−SEG levels than any off pixel.
- R11: A configuration change takes effect only at the next frame boundary. The frame then restarts at common 0 with positive phase.
- R12: In Type-A at 1/3 and 1/4 multiplex, LP is used with its lowest bit forced to 1. The frame therefore lasts N·((LP|1)+1) ticks, so each slot splits into two equal halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | LCD source clock enable; one tick per high cycle |
| lp_in | input | LP_W | Prescaler value LP |
| mux_in | input | 2 | Multiplex ratio: 0 static, 1 half, 2 third, 3 quarter |
| type_b_in | input | 1 | 0 selects Type-A balancing, 1 selects Type-B |
| pix_in | input | 4·NSEG | Pixel array, bit common·NSEG+segment, 1 = on |
| com_lvl | output | 4·2 | Bias-ladder index per common, common c in bits 2c+1:2c |
| seg_lvl | output | NSEG·2 | Bias-ladder index per segment, segment s in bits 2s+1:2s |
| frame_strobe | output | 1 | One-cycle pulse at the start of each frame |
| phase_o | output | 1 | Current polarity, 0 positive, 1 negative |

## Verification
The most sensitive symptom of an internal fault is DC imbalance. A wrong slot counter, an inverted sub-slot flag or a missed Type-B toggle leaves a non-zero COM−SEG sum on some pixel, and this shows within one frame (Type-A) or two frames (Type-B). A corrupted prescaler or a bad common-index wrap shows at the next strobe as a wrong frame length. A wrong scan order or a stale configuration register shows in the levels of the very first cycle of a frame. A state-machine fault that leaves the block in `ST_IDLE`, or one that lets outputs move without a tick, is visible on the first cycle it affects.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    localparam int MAX_COM = 4;
    localparam int LVL_W   = 2;

    typedef enum logic [1:0] {
        MUX_STATIC  = 2'd0,
        MUX_HALF    = 2'd1,
        MUX_THIRD   = 2'd2,
        MUX_QUARTER = 2'd3
    } mux_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/lcd_geom.sv
// Derives slot length, halves per slot, last common and bias from the
// configuration currently in force.
module lcd_geom
    import lcd_pkg::*;
#(
    parameter int LP_W  = 4,
    parameter int CNT_W = LP_W + 2
) (
    input  mux_e             mode,
    input  logic [LP_W-1:0]  lp,
    input  logic             type_b,
    output logic [CNT_W-1:0] len_m1,
    output logic             two_sub,
    output logic [1:0]       last_com,
    output logic [LVL_W-1:0] bias
);
    logic [CNT_W-1:0] lp_x;

    always_comb begin
        lp_x     = CNT_W'(lp);
        last_com = mode;
        two_sub  = !((mode == MUX_THIRD || mode == MUX_QUARTER) && type_b);
        unique case (mode)
            MUX_STATIC: begin
                len_m1 = (lp_x << 1) + CNT_W'(1);
                bias   = LVL_W'(1);
            end
            MUX_HALF: begin
                len_m1 = lp_x;
                bias   = LVL_W'(2);
            end
            default: begin
                len_m1 = type_b ? lp_x : (lp_x >> 1);
                bias   = LVL_W'(3);
            end
        endcase
    end
endmodule

// File: rtl/lcd_level_map.sv
// Maps one line's role to a bias-ladder index; IS_COM picks the variant.
module lcd_level_map
    import lcd_pkg::*;
#(
    parameter bit IS_COM = 1'b1
) (
    input  logic [LVL_W-1:0] bias,
    input  logic             neg,
    input  logic             sel,
    output logic [LVL_W-1:0] level
);
    logic [LVL_W-1:0] pos;

    generate
        if (IS_COM) begin : g_com
            always_comb pos = sel ? bias : ((bias == LVL_W'(1)) ? LVL_W'(0) : LVL_W'(1));
        end else begin : g_seg
            always_comb pos = sel ? LVL_W'(0) : ((bias == LVL_W'(3)) ? LVL_W'(2) : bias);
        end
    endgenerate

    always_comb level = neg ? (bias - pos) : pos;
endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
    import lcd_pkg::*;
#(
    parameter int NSEG = 8,
    parameter int LP_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [LP_W-1:0]          lp_in,
    input  logic [1:0]               mux_in,
    input  logic                     type_b_in,
    input  logic [MAX_COM*NSEG-1:0]  pix_in,
    output logic [MAX_COM*LVL_W-1:0] com_lvl,
    output logic [NSEG*LVL_W-1:0]    seg_lvl,
    output logic                     frame_strobe,
    output logic                     phase_o
);
    localparam int CNT_W = LP_W + 2;

    seq_state_e       state;
    mux_e             cfg_mode;
    logic [LP_W-1:0]  cfg_lp;
    logic             cfg_b;
    logic [1:0]       com_idx;
    logic             sub;
    logic [CNT_W-1:0] cnt;
    logic             phase_b;
    logic             strobe_q;

    logic [CNT_W-1:0] len_m1;
    logic             two_sub;
    logic [1:0]       last_com;
    logic [LVL_W-1:0] bias;
    logic             cfg_chg;
    logic             neg;
    logic [NSEG-1:0]  row;

    logic [MAX_COM*LVL_W-1:0] com_raw;
    logic [NSEG*LVL_W-1:0]    seg_raw;

    lcd_geom #(.LP_W(LP_W), .CNT_W(CNT_W)) u_geom (
        .mode     (cfg_mode),
        .lp       (cfg_lp),
        .type_b   (cfg_b),
        .len_m1   (len_m1),
        .two_sub  (two_sub),
        .last_com (last_com),
        .bias     (bias)
    );

    always_comb begin
        cfg_chg = (mux_e'(mux_in) != cfg_mode) || (lp_in != cfg_lp) || (type_b_in != cfg_b);
        neg     = cfg_b ? phase_b : sub;
        for (int s = 0; s < NSEG; s++) begin
            row[s] = pix_in[int'(com_idx) * NSEG + s];
        end
    end

    // State register: slot counter, half flag, common index, frame polarity.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cfg_mode <= MUX_STATIC;
            cfg_lp   <= '0;
            cfg_b    <= 1'b0;
            com_idx  <= '0;
            sub      <= 1'b0;
            cnt      <= '0;
            phase_b  <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        cfg_mode <= mux_e'(mux_in);
                        cfg_lp   <= lp_in;
                        cfg_b    <= type_b_in;
                        com_idx  <= '0;
                        sub      <= 1'b0;
                        cnt      <= '0;
                        phase_b  <= 1'b0;
                        strobe_q <= 1'b1;
                        state    <= ST_RUN;
                    end
                    ST_RUN: begin
                        if (cnt != len_m1) begin
                            cnt <= cnt + CNT_W'(1);
                        end else begin
                            cnt <= '0;
                            if (two_sub && !sub) begin
                                sub <= 1'b1;
                            end else begin
                                sub <= 1'b0;
                                if (com_idx != last_com) begin
                                    com_idx <= com_idx + 2'd1;
                                end else begin
                                    com_idx  <= '0;
                                    cfg_mode <= mux_e'(mux_in);
                                    cfg_lp   <= lp_in;
                                    cfg_b    <= type_b_in;
                                    phase_b  <= (cfg_chg || !type_b_in) ? 1'b0 : ~phase_b;
                                    strobe_q <= 1'b1;
                                end
                            end
                        end
                    end
                endcase
            end
        end
    end

    genvar gc, gs;
    generate
        for (gc = 0; gc < MAX_COM; gc++) begin : g_com_line
            lcd_level_map #(.IS_COM(1'b1)) u_map (
                .bias  (bias),
                .neg   (neg),
                .sel   (com_idx == 2'(gc)),
                .level (com_raw[gc*LVL_W +: LVL_W])
            );
        end
        for (gs = 0; gs < NSEG; gs++) begin : g_seg_line
            lcd_level_map #(.IS_COM(1'b0)) u_map (
                .bias  (bias),
                .neg   (neg),
                .sel   (row[gs]),
                .level (seg_raw[gs*LVL_W +: LVL_W])
            );
        end
    endgenerate

    // Output process: blank while idle, otherwise pass the mapped levels.
    always_comb begin
        frame_strobe = strobe_q;
        if (state == ST_RUN) begin
            phase_o = neg;
            com_lvl = com_raw;
            seg_lvl = seg_raw;
        end else begin
            phase_o = 1'b0;
            com_lvl = '0;
            seg_lvl = '0;
        end
    end
endmodule

// File: rtl/lcd_wave_seq_chk.sv
module lcd_wave_seq_chk
    import lcd_pkg::*;
#(
    parameter int NSEG = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tick,
    input logic [MAX_COM*LVL_W-1:0] com_lvl,
    input logic [NSEG*LVL_W-1:0]    seg_lvl,
    input logic                     frame_strobe,
    input logic                     phase_o,
    input logic [1:0]               cfg_mode,
    input logic                     cfg_b
);
    logic any_hi;

    always_comb begin
        any_hi = 1'b0;
        for (int c = 0; c < MAX_COM; c++) any_hi = any_hi | com_lvl[c*LVL_W + 1];
        for (int s = 0; s < NSEG; s++) any_hi = any_hi | seg_lvl[s*LVL_W + 1];
    end

    p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> !frame_strobe);

    p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(com_lvl) && $stable(seg_lvl) && $stable(phase_o) && !frame_strobe));

    p_static_levels_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0) |-> !any_hi);

    p_typea_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !cfg_b) |-> !phase_o);

    p_typeb_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_b && (phase_o != $past(phase_o))) |-> frame_strobe);
endmodule

bind lcd_wave_seq lcd_wave_seq_chk #(.NSEG(NSEG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .com_lvl      (com_lvl),
    .seg_lvl      (seg_lvl),
    .frame_strobe (frame_strobe),
    .phase_o      (phase_o),
    .cfg_mode     (cfg_mode),
    .cfg_b        (cfg_b)
);

// File: tb/sim_lcd_wave_seq.sv
module sim_lcd_wave_seq;
    localparam int NSEG = 8;
    localparam int LP_W = 4;
    localparam int NC   = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 tick = 1'b0;
    logic [LP_W-1:0]      lp_in = 4'd1;
    logic [1:0]           mux_in = 2'd3;
    logic                 type_b_in = 1'b0;
    logic [NC*NSEG-1:0]   pix_in = 32'hA5C3_0F69;
    logic [NC*2-1:0]      com_lvl;
    logic [NSEG*2-1:0]    seg_lvl;
    logic                 frame_strobe;
    logic                 phase_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    lcd_wave_seq #(.NSEG(NSEG), .LP_W(LP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lp_in(lp_in), .mux_in(mux_in),
        .type_b_in(type_b_in), .pix_in(pix_in), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
        .frame_strobe(frame_strobe), .phase_o(phase_o)
    );

    function automatic int cl(int c);
        return int'(com_lvl[2*c +: 2]);
    endfunction

    function automatic int sl(int s);
        return int'(seg_lvl[2*s +: 2]);
    endfunction

    function automatic int bias_of(int m);
        return (m == 0) ? 1 : ((m == 1) ? 2 : 3);
    endfunction

    function automatic int exp_frame(int m, int lp, bit b);
        if (m <= 1) return 4 * (lp + 1);
        if (b) return (m + 1) * (lp + 1);
        return (m + 1) * ((lp | 1) + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!frame_strobe && cyc < 1000);
    endtask

    task automatic set_cfg(input int m, input int lp, input bit b);
        int cyc;
        mux_in    = m[1:0];
        lp_in     = lp[LP_W-1:0];
        type_b_in = b;
        wait_strobe(cyc);
    endtask

    // R1, R3, R5, R6, R8: reset state and the first quarter-multiplex frame
    task automatic t_reset();
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(com_lvl == '0 && seg_lvl == '0, "R1 idle levels", int'(com_lvl), 0);
        check(!frame_strobe && !phase_o, "R1 idle strobe/phase", int'({frame_strobe, phase_o}), 0);
        tick = 1'b1;
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            int act_c;
            bit ng;
            bit ok;
            @(negedge clk);
            act_c = k / 2;
            ng = bit'(k % 2);
            ok = (phase_o == ng) && (frame_strobe == (k == 0));
            for (int c = 0; c < 4; c++)
                ok &= (cl(c) == ((c == act_c) ? (ng ? 0 : 3) : (ng ? 2 : 1)));
            for (int s = 0; s < NSEG; s++)
                ok &= (sl(s) == (pix_in[act_c*NSEG + s] ? (ng ? 3 : 0) : (ng ? 1 : 2)));
            if (!ok) bad++;
        end
        check(bad == 0, "R5 R6 R8 scan and levels", bad, 0);
        @(negedge clk);
        check(frame_strobe == 1'b1, "R2 R3 quarter A LP1 8 ticks", int'(frame_strobe), 1);
    endtask

    // R2, R12: frame length per mode
    task automatic t_period(input int m, input int lp, input bit b, input string tag);
        int c1;
        int c2;
        int e;
        set_cfg(m, lp, b);
        e = exp_frame(m, lp, b);
        wait_strobe(c1);
        wait_strobe(c2);
        check(c1 == e && c2 == e, tag, c1 * 1000 + c2, e * 1000 + e);
    endtask

    // R11, R9: configuration changes wait for the frame boundary
    task automatic t_change();
        int c;
        set_cfg(0, 3, 0);
        repeat (5) @(negedge clk);
        mux_in = 2'd1;
        lp_in  = 4'd0;
        wait_strobe(c);
        check(c == 11, "R11 old frame completes", c, 11);
        check(!phase_o && cl(0) == 2, "R11 restart common0 positive", cl(0) + 10 * int'(phase_o), 2);
        wait_strobe(c);
        check(c == 4, "R11 new length applies", c, 4);
        set_cfg(3, 0, 1);
        check(!phase_o, "R11 Type-B start positive", int'(phase_o), 0);
        wait_strobe(c);
        check(phase_o, "R9 Type-B toggles", int'(phase_o), 1);
        wait_strobe(c);
        check(!phase_o, "R9 Type-B toggles back", int'(phase_o), 0);
        lp_in = 4'd1;
        wait_strobe(c);
        check(c == 4 && !phase_o, "R11 Type-B change restarts positive", c * 10 + int'(phase_o), 40);
        wait_strobe(c);
        check(c == 8 && phase_o, "R9 new LP period and toggle", c * 10 + int'(phase_o), 81);
    endtask

    // R6, R8, R9, R10: DC balance and rms ordering over a balanced window
    task automatic t_dc(input int m, input int lp, input bit b);
        int sum[NC][NSEG];
        int sq[NC][NSEG];
        int f;
        int win;
        int nph;
        int maxl;
        int bad;
        int min_on;
        int max_off;
        set_cfg(m, lp, b);
        f = exp_frame(m, lp, b);
        win = b ? 2 * f : f;
        nph = 0;
        maxl = 0;
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NSEG; s++) begin
                sum[c][s] = 0;
                sq[c][s] = 0;
            end
        for (int k = 0; k < win; k++) begin
            if (k > 0) @(negedge clk);
            if (phase_o) nph++;
            for (int c = 0; c < NC; c++) if (cl(c) > maxl) maxl = cl(c);
            for (int s = 0; s < NSEG; s++) if (sl(s) > maxl) maxl = sl(s);
            for (int c = 0; c <= m; c++)
                for (int s = 0; s < NSEG; s++) begin
                    int d;
                    d = cl(c) - sl(s);
                    sum[c][s] += d;
                    sq[c][s] += d * d;
                end
        end
        @(negedge clk);
        check(frame_strobe == 1'b1, "R3 strobe after window", int'(frame_strobe), 1);
        bad = 0;
        min_on = 1 << 30;
        max_off = -1;
        for (int c = 0; c <= m; c++)
            for (int s = 0; s < NSEG; s++) begin
                if (sum[c][s] != 0) bad++;
                if (pix_in[c*NSEG + s]) begin
                    if (sq[c][s] < min_on) min_on = sq[c][s];
                end else begin
                    if (sq[c][s] > max_off) max_off = sq[c][s];
                end
            end
        if (b) check(bad == 0, "R9 two-frame DC sum", bad, 0);
        else   check(bad == 0, "R8 one-frame DC sum", bad, 0);
        check(min_on > max_off, "R10 on rms above off rms", min_on, max_off + 1);
        check(maxl <= bias_of(m), "R6 level within bias", maxl, bias_of(m));
        check(nph == win / 2, "R8 R9 negative phase share", nph, win / 2);
    endtask

    // R7: commons above the multiplex count
    task automatic t_unused();
        int bad;
        set_cfg(1, 1, 0);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            if (cl(2) != 1 || cl(3) != 1) bad++;
        end
        check(bad == 0, "R7 half mode unused commons at 1", bad, 0);
        set_cfg(0, 0, 0);
        bad = 0;
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            for (int c = 1; c < 4; c++) if (cl(c) != int'(phase_o)) bad++;
        end
        check(bad == 0, "R7 static unused commons track phase", bad, 0);
    endtask

    // R4: sparse ticks
    task automatic t_tick_gate();
        int last;
        int bad_gap;
        int bad_hold;
        bit prev_tick;
        logic [NC*2-1:0] pc;
        logic [NSEG*2-1:0] ps;
        logic pp;
        set_cfg(0, 0, 0);
        last = -1;
        bad_gap = 0;
        bad_hold = 0;
        prev_tick = 1'b1;
        pc = com_lvl;
        ps = seg_lvl;
        pp = phase_o;
        for (int k = 0; k < 72; k++) begin
            tick = (k % 3 == 0);
            prev_tick = tick;
            @(negedge clk);
            if (!prev_tick && (com_lvl != pc || seg_lvl != ps || phase_o != pp || frame_strobe))
                bad_hold++;
            if (frame_strobe) begin
                if (last >= 0 && (k - last) != 12) bad_gap++;
                last = k;
            end
            pc = com_lvl;
            ps = seg_lvl;
            pp = phase_o;
        end
        tick = 1'b1;
        check(bad_hold == 0, "R4 outputs hold without tick", bad_hold, 0);
        check(bad_gap == 0 && last >= 0, "R4 frame counts ticks not cycles", bad_gap, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_period(0, 3, 0, "R2 static LP3");
        t_period(1, 2, 0, "R2 half LP2");
        t_period(2, 4, 1, "R2 third Type-B LP4");
        t_period(3, 0, 1, "R2 quarter Type-B LP0");
        t_period(2, 2, 0, "R12 third Type-A even LP rounds up");
        t_period(3, 5, 0, "R2 R12 quarter Type-A odd LP");
        t_change();
        t_dc(3, 1, 0);
        t_dc(2, 4, 1);
        t_dc(1, 2, 0);
        t_dc(0, 2, 1);
        t_dc(3, 2, 0);
        t_dc(2, 3, 0);
        t_unused();
        t_tick_gate();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule